// File: doc/BRIEF.md
# Frame Word Mismatch Checker

The block holds a received frame and a reference frame in two small word buffers and, on command, walks both with one shared index, comparing one word per clock cycle. Word equality is not a wide XOR-and-reduce. It is a serial chain of per-bit mux stages. The chain is seeded with "equal", and any stage whose bit pair differs forces the running value to zero.

The first differing word ends the walk at once. The block then shows a finished indication with the bad-frame flag set. A frame in which every word matches finishes with the flag low. Both buffers are filled through write ports with a valid/ready handshake. Each port's ready is high whenever no comparison is running. While a comparison runs, ready is low and the port accepts nothing. A writer that raises valid at that time must hold its word until ready returns. A word transfers on a clock edge where valid and ready are both high. The start and length inputs and the done and bad-frame outputs are plain level signals.

Top module: `frame_word_checker`

## Requirements
- R1: After reset, done and bad_frame are 0, and rx_ready and ref_ready are 1.
- R2: A start pulse while no comparison is running, with a non-zero length, begins a comparison at index 0. On the next cycle done is 0 and bad_frame is 0, even after a failed frame.
- R3: Words are compared one per cycle, starting at index 0. When all L words match, done rises L+1 clock edges after the start edge, with bad_frame 0.
- R4: When word m is the first mismatch, done rises m+2 clock edges after the start edge, with bad_frame 1. Mismatches after index m do not change this timing.
- R5: The comparison flags a word when its two operands differ in any one of the 32 bit positions. Identical words are never flagged.
- R6: A length of 0 gives done 1 and bad_frame 0 on the edge after start.
- R7: A length greater than the buffer depth (16 by default) is treated as the full depth.
- R8: During a comparison, rx_ready and ref_ready are 0, and writes offered with valid are not stored. Outside a comparison, a write with valid high stores its data at the given index.
- R9: A start pulse during a comparison is ignored. The current frame finishes with its own length.
- R10: done and bad_frame hold their values until the next start. bad_frame is never 1 while done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a comparison (ignored while busy) |
| frame_len | input | LEN_W (5) | Number of words to compare |
| rx_valid | input | 1 | Received-word write offered |
| rx_ready | output | 1 | Received buffer accepts a write |
| rx_idx | input | IDX_W (4) | Received-word write index |
| rx_data | input | WORD_W (32) | Received-word write data |
| ref_valid | input | 1 | Reference-word write offered |
| ref_ready | output | 1 | Reference buffer accepts a write |
| ref_idx | input | IDX_W (4) | Reference-word write index |
| ref_data | input | WORD_W (32) | Reference-word write data |
| done | output | 1 | Comparison finished |
| bad_frame | output | 1 | Finished frame had a mismatching word |

## Verification
The bench flips every one of the 32 bit positions in turn. A chain stage that passes its carry when the bits differ, or that is wired to the wrong bit, would miss exactly those positions.

It moves the first mismatch across every index, and adds a second mismatch later in the frame. A checker that keeps running past the first mismatch, or that reports one cycle late, would then show the wrong finish time.

It sweeps every length from zero up past the buffer depth. An off-by-one terminal index, a zero length that hangs or falsely flags, or a missing clamp would each give a wrong finish cycle. Writes and restarts issued mid-comparison must leave the result untouched, which exposes any ready that stays high while busy.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_DONE = 2'd2
  } fwc_state_t;
endpackage

// File: rtl/fwc_eq_chain.sv
// Serial propagate/kill equality: carry starts at 1, each stage keeps it
// only when its bit pair agrees.
module fwc_eq_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             eq
);
  logic [WIDTH:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic bit_same;
    assign bit_same   = ~(a[i] ^ b[i]);
    assign carry[i+1] = bit_same ? carry[i] : 1'b0;
  end

  assign eq = carry[WIDTH];
endmodule

// File: rtl/fwc_word_store.sv
module fwc_word_store #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fwc_ctrl.sv
module fwc_ctrl
  import fwc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             words_eq,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             done,
  output logic             bad
);
  fwc_state_t       state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] last_idx;
  logic [LEN_W-1:0] len_eff;

  always_comb begin
    len_eff = (frame_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : frame_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      last_idx <= '0;
      bad      <= 1'b0;
    end else begin
      case (state)
        ST_CMP: begin
          if (!words_eq) begin
            bad   <= 1'b1;
            state <= ST_DONE;
          end else if (cnt == last_idx) begin
            state <= ST_DONE;
          end else begin
            cnt <= cnt + IDX_W'(1);
          end
        end
        default: begin
          if (start) begin
            cnt      <= '0;
            bad      <= 1'b0;
            last_idx <= IDX_W'(len_eff - LEN_W'(1));
            state    <= (len_eff == '0) ? ST_DONE : ST_CMP;
          end
        end
      endcase
    end
  end

  assign rd_idx = cnt;
  assign busy   = (state == ST_CMP);
  assign done   = (state == ST_DONE);
endmodule

// File: rtl/frame_word_checker.sv
module frame_word_checker #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [IDX_W-1:0]  ref_idx,
  input  logic [WORD_W-1:0] ref_data,
  output logic              done,
  output logic              bad_frame
);
  logic              busy;
  logic              words_eq;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] ref_word;

  assign rx_ready  = ~busy;
  assign ref_ready = ~busy;

  fwc_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rx_store (
    .clk     (clk),
    .wr_en   (rx_valid & rx_ready),
    .wr_idx  (rx_idx),
    .wr_data (rx_data),
    .rd_idx  (rd_idx),
    .rd_data (rx_word)
  );

  fwc_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ref_store (
    .clk     (clk),
    .wr_en   (ref_valid & ref_ready),
    .wr_idx  (ref_idx),
    .wr_data (ref_data),
    .rd_idx  (rd_idx),
    .rd_data (ref_word)
  );

  fwc_eq_chain #(.WIDTH(WORD_W)) u_chain (
    .a  (rx_word),
    .b  (ref_word),
    .eq (words_eq)
  );

  fwc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame_len (frame_len),
    .words_eq  (words_eq),
    .rd_idx    (rd_idx),
    .busy      (busy),
    .done      (done),
    .bad       (bad_frame)
  );
endmodule

// File: rtl/fwc_checker.sv
module fwc_checker #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  frame_len,
  input logic              rx_ready,
  input logic              ref_ready,
  input logic              busy,
  input logic              words_eq,
  input logic [WORD_W-1:0] rx_word,
  input logic [WORD_W-1:0] ref_word,
  input logic              done,
  input logic              bad_frame
);
  // R5
  chain_vs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (words_eq == (rx_word == ref_word)));

  // R4
  stop_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !words_eq) |=> (done && bad_frame));

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && frame_len == '0) |=> (done && !bad_frame));

  // R2
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && frame_len != '0) |=> (!done && !bad_frame));

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rx_ready && !ref_ready));

  // R10
  bad_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_frame |-> done);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(bad_frame)));
endmodule

bind frame_word_checker fwc_checker #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_fwc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .frame_len (frame_len),
  .rx_ready  (rx_ready),
  .ref_ready (ref_ready),
  .busy      (busy),
  .words_eq  (words_eq),
  .rx_word   (rx_word),
  .ref_word  (ref_word),
  .done      (done),
  .bad_frame (bad_frame)
);

// File: tb/frame_word_checker_bench.sv
`timescale 1ns/1ps
module frame_word_checker_bench;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LEN_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  frame_len = '0;
  logic              rx_valid = 1'b0;
  logic              rx_ready;
  logic [IDX_W-1:0]  rx_idx = '0;
  logic [WORD_W-1:0] rx_data = '0;
  logic              ref_valid = 1'b0;
  logic              ref_ready;
  logic [IDX_W-1:0]  ref_idx = '0;
  logic [WORD_W-1:0] ref_data = '0;
  logic              done;
  logic              bad_frame;

  int  n_checks = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  frame_word_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_frame_word_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_idx(rx_idx), .rx_data(rx_data),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_idx(ref_idx), .ref_data(ref_data),
    .done(done), .bad_frame(bad_frame)
  );

  function automatic logic [WORD_W-1:0] pat(input int i);
    return 32'hA5C3_0F01 ^ (32'h0100_0193 * (i + 7));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_rx(input int idx, input logic [WORD_W-1:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_idx = IDX_W'(idx); rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wr_ref(input int idx, input logic [WORD_W-1:0] d);
    @(negedge clk);
    ref_valid = 1'b1; ref_idx = IDX_W'(idx); ref_data = d;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  // Pulses start and counts clock edges until done is seen.
  task automatic run_frame(input int len, input int exp_n, input bit exp_bad, input string req);
    int n;
    @(negedge clk);
    start = 1'b1; frame_len = LEN_W'(len);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      if (n == 0) start = 1'b0;
      n++;
      if (n == 1 && len != 0)
        check(!done && !bad_frame, "R2", {done, bad_frame}, 0);
    end while (!done && n < 100);
    check(n == exp_n, req, n, exp_n);
    check(bad_frame == exp_bad, req, bad_frame, exp_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1
    check(!done && !bad_frame, "R1", {done, bad_frame}, 0);
    check(rx_ready && ref_ready, "R1", {rx_ready, ref_ready}, 3);

    for (int i = 0; i < DEPTH; i++) begin
      wr_rx(i, pat(i));
      wr_ref(i, pat(i));
    end

    // R3: every length, all words equal
    for (int l = 1; l <= DEPTH; l++) run_frame(l, l + 1, 1'b0, "R3");

    // R6
    run_frame(0, 1, 1'b0, "R6");

    // R7
    run_frame(DEPTH + 4, DEPTH + 1, 1'b0, "R7");
    run_frame((1 << LEN_W) - 1, DEPTH + 1, 1'b0, "R7");

    // R4: first mismatch swept over all indices, with a later mismatch too
    for (int m = 0; m < DEPTH; m++) begin
      wr_rx(m, pat(m) ^ 32'h0000_0100);
      if (m < DEPTH - 1) wr_rx(DEPTH - 1, ~pat(DEPTH - 1));
      run_frame(DEPTH, m + 2, 1'b1, "R4");
      wr_rx(m, pat(m));
      wr_rx(DEPTH - 1, pat(DEPTH - 1));
    end

    // R10: result holds while no start
    for (int k = 0; k < 4; k++) begin
      wr_rx(0, ~pat(0));
    end
    run_frame(3, 2, 1'b1, "R10");
    repeat (4) begin
      @(negedge clk);
      check(done && bad_frame, "R10", {done, bad_frame}, 3);
    end
    wr_rx(0, pat(0));

    // R5: each single bit position flagged, equal patterns never flagged
    for (int b = 0; b < WORD_W; b++) begin
      wr_rx(2, pat(2) ^ (32'h1 << b));
      run_frame(3, 4, 1'b1, "R5");
    end
    wr_rx(2, pat(2));
    foreach (n_bad_pats[j]) begin
      wr_rx(1, n_bad_pats[j]);
      wr_ref(1, n_bad_pats[j]);
      run_frame(2, 3, 1'b0, "R5");
    end
    wr_rx(1, pat(1));
    wr_ref(1, pat(1));

    // R8: writes during comparison are refused and not stored
    @(negedge clk);
    start = 1'b1; frame_len = LEN_W'(8);
    @(negedge clk);
    start = 1'b0;
    check(!rx_ready && !ref_ready, "R8", {rx_ready, ref_ready}, 0);
    rx_valid = 1'b1; rx_idx = IDX_W'(6); rx_data = ~pat(6);
    ref_valid = 1'b1; ref_idx = IDX_W'(7); ref_data = ~pat(7);
    @(negedge clk);
    rx_valid = 1'b0; ref_valid = 1'b0;
    n = 2;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 9, "R8", n, 9);
    check(!bad_frame, "R8", bad_frame, 0);
    check(rx_ready && ref_ready, "R8", {rx_ready, ref_ready}, 3);
    run_frame(8, 9, 1'b0, "R8");

    // R9: start with zero length mid-comparison is ignored
    @(negedge clk);
    start = 1'b1; frame_len = LEN_W'(DEPTH);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; frame_len = '0;
    @(negedge clk);
    start = 1'b0;
    n = 4;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == DEPTH + 1, "R9", n, DEPTH + 1);
    check(!bad_frame, "R9", bad_frame, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  logic [WORD_W-1:0] n_bad_pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_5555, 32'h8000_0001};
endmodule